// File: doc/BRIEF.md
# NAND Ready/Busy Status and Interrupt Register Block

This block is the small register slice of a NAND flash controller that watches the flash ready/busy line and records DMA completion. It drives the flash chip-enable lines and raises an interrupt request. Software reaches it through a byte-wide register port with two mapped addresses. The control register at address 0 holds the interrupt enable, the chip-enable selects and the chip-enable mode, and it reads back the controller's busy flag. The status register at address 1 holds the interrupt-pending and DMA-done event flags, shows the live ready/busy level, and stores the configuration fields that other controller blocks use: wait states, wait-state strobe level and address-cycle count.

The ready/busy input comes from open-drain outputs wired together with a pull-up, so it is asynchronous. It passes through a synchroniser before any edge detection. A ready/busy low-to-high transition latches the pending flag. The interrupt line is the pending flag gated by the enable bit. The DMA-done flag is set by a pulse from the DMA engine. Software clears it by writing one, and a new controller command also clears it. On both event flags a hardware set wins over a clear in the same cycle.

The chip-enable outputs are active low. In direct mode each output follows its own select bit in the control register. In decoded mode exactly one output goes low, and only while an external memory access is in progress. An index field in the access address picks that output.

Top module: `nsr_status_regs`

## Requirements
- R1: After reset, address 0 reads 0x00 (with the busy input low), address 1 reads 0x40 when the ready/busy pin is high, all chip-enable outputs are high, and irq is low.
- R2: A low-to-high transition of the ready/busy pin sets bit 7 of address 1 (pending) at the SYNC_STAGES+1-th rising clock edge after the pin changes, once per transition. A high-to-low transition or a level held high does not set it.
- R3: Writing address 1 with bit 7 set clears the pending flag. Writing it with bit 7 clear leaves the flag unchanged.
- R4: irq is high exactly when bit 6 of address 0 (interrupt enable) is 1 and the pending flag is set. Clearing either one drops irq in the next cycle.
- R5: Bit 6 of address 1 reads the synchronised ready/busy level, which follows the pin after SYNC_STAGES rising clock edges.
- R6: Bit 5 of address 1 (DMA done) is set one cycle after a dma_done_pulse. It is cleared by writing address 1 with bit 5 set, or by a cmd_issue pulse. Writing bit 5 as 0 has no effect.
- R7: When a set event and a clear (a write-one clear or cmd_issue) reach an event flag in the same cycle, the flag ends up set.
- R8: When bit 1 of address 0 is 1, ce_n[i] is the inverse of bit 2+i of address 0. Bits 5:2 and bit 1 read back as written.
- R9: When bit 1 of address 0 is 0, ce_n[i] is low only while ext_access is high and ext_addr[CE_SEL_LSB +: 2] equals i. At most one ce_n is low.
- R10: Bit 0 of address 0 reads the live ctrl_busy input, and bit 7 reads 0. Writes to those bits, and writes to any address other than 0 and 1, change nothing, and unmapped addresses read 0.
- R11: Bits 4:0 of address 1 read back as written and drive cfg_wait_states (bits 4:3), cfg_wait_low (bit 2) and cfg_addr_cycles (bits 1:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_ADDR_W | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| rb_pin | input | 1 | Asynchronous wired-OR ready/busy input, 1 = ready |
| ctrl_busy | input | 1 | Controller busy flag |
| dma_done_pulse | input | 1 | One-cycle pulse at the end of a DMA transfer |
| cmd_issue | input | 1 | One-cycle pulse when a controller command is issued |
| ext_access | input | 1 | External memory access in progress |
| ext_addr | input | EXT_ADDR_W | External access address, carries the chip-enable index |
| ce_n | output | NUM_CE | Active-low chip enables |
| irq | output | 1 | Interrupt request |
| cfg_wait_states | output | 2 | Wait-state count for the DMA engine |
| cfg_wait_low | output | 1 | Strobe level during wait states |
| cfg_addr_cycles | output | 2 | Address-cycle select |

## Verification
The bench builds the block with four chip enables, a two-stage synchroniser, an 8-bit external address and the chip-enable index in bits 7:6. With these values the index can be set directly with a short address, and every chip-enable output can be driven in both modes. The two-stage synchroniser makes the pending-flag latency three edges, short enough to line up a software clear exactly on the cycle where the edge detector fires. The same timing puts a DMA-done pulse in the same cycle as a write-one clear or a command pulse, so the set-wins rule can be checked on both flags.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  localparam int DW = 8;

  // control register (address 0) bit positions
  localparam int CTRL_BUSY      = 0;
  localparam int CTRL_CE_DIRECT = 1;
  localparam int CTRL_CE_BASE   = 2;
  localparam int CTRL_IRQ_EN    = 6;

  // status register (address 1) bit positions
  localparam int STAT_CFG_W = 5;
  localparam int STAT_DMA   = 5;
  localparam int STAT_RB    = 6;
  localparam int STAT_PEND  = 7;

  // configuration fields, packed in register bit order 4:0
  typedef struct packed {
    logic [1:0] wait_states;
    logic       wait_low;
    logic [1:0] addr_cycles;
  } cfg_t;

  // event flag update: a set in the same cycle as a clear wins
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

  // one chip-enable lane, active high
  function automatic logic ce_lane_active(input logic direct, input logic sel_bit,
                                          input logic access, input logic hit);
    return direct ? sel_bit : (access & hit);
  endfunction

endpackage

// File: rtl/nsr_rb_sync.sv
module nsr_rb_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= IDLE;
        else        chain_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nsr_event_flag.sv
module nsr_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import nsr_pkg::*;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_i, clr_i);

  assign flag_o = flag_q;
endmodule

// File: rtl/nsr_ce_mux.sv
module nsr_ce_mux #(
  parameter int NUM_CE = 4,
  parameter int SEL_W  = 2
) (
  input  logic              direct_i,
  input  logic [NUM_CE-1:0] sel_i,
  input  logic              access_i,
  input  logic [SEL_W-1:0]  idx_i,
  output logic [NUM_CE-1:0] ce_n_o
);
  import nsr_pkg::*;

  generate
    for (genvar i = 0; i < NUM_CE; i++) begin : g_lane
      logic hit;
      assign hit       = (idx_i == SEL_W'(i));
      assign ce_n_o[i] = ~ce_lane_active(direct_i, sel_i[i], access_i, hit);
    end
  endgenerate
endmodule

// File: rtl/nsr_status_regs.sv
module nsr_status_regs #(
  parameter int REG_ADDR_W  = 4,
  parameter int NUM_CE      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_ADDR_W  = 16,
  parameter int CE_SEL_LSB  = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic                  rb_pin,
  input  logic                  ctrl_busy,
  input  logic                  dma_done_pulse,
  input  logic                  cmd_issue,
  input  logic                  ext_access,
  input  logic [EXT_ADDR_W-1:0] ext_addr,
  output logic [NUM_CE-1:0]     ce_n,
  output logic                  irq,
  output logic [1:0]            cfg_wait_states,
  output logic                  cfg_wait_low,
  output logic [1:0]            cfg_addr_cycles
);
  import nsr_pkg::*;

  localparam int SEL_W = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = '0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = REG_ADDR_W'(1);

  // named internal events
  logic wr_ctrl, wr_stat;
  logic rb_level, rb_rise;
  logic pend_clr, dma_clr;
  logic pend_flag, dma_flag;
  logic irq_en_q, ce_direct_q;
  logic [NUM_CE-1:0] ce_sel_q;
  cfg_t cfg_q;
  logic [SEL_W-1:0] ce_idx;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

  nsr_rb_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(rb_pin),
    .level_o(rb_level), .rise_o(rb_rise)
  );

  assign pend_clr = wr_stat & reg_wdata[STAT_PEND];
  assign dma_clr  = (wr_stat & reg_wdata[STAT_DMA]) | cmd_issue;

  nsr_event_flag u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(rb_rise), .clr_i(pend_clr), .flag_o(pend_flag)
  );

  nsr_event_flag u_dma (
    .clk(clk), .rst_n(rst_n), .set_i(dma_done_pulse), .clr_i(dma_clr), .flag_o(dma_flag)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_en_q    <= 1'b0;
      ce_direct_q <= 1'b0;
      ce_sel_q    <= '0;
    end else if (wr_ctrl) begin
      irq_en_q    <= reg_wdata[CTRL_IRQ_EN];
      ce_direct_q <= reg_wdata[CTRL_CE_DIRECT];
      ce_sel_q    <= reg_wdata[CTRL_CE_BASE +: NUM_CE];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cfg_q <= '0;
    else if (wr_stat) cfg_q <= cfg_t'(reg_wdata[STAT_CFG_W-1:0]);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[CTRL_BUSY]                 = ctrl_busy;
      reg_rdata[CTRL_CE_DIRECT]            = ce_direct_q;
      reg_rdata[CTRL_CE_BASE +: NUM_CE]    = ce_sel_q;
      reg_rdata[CTRL_IRQ_EN]               = irq_en_q;
    end else if (reg_addr == ADDR_STAT) begin
      reg_rdata[STAT_CFG_W-1:0] = cfg_q;
      reg_rdata[STAT_DMA]       = dma_flag;
      reg_rdata[STAT_RB]        = rb_level;
      reg_rdata[STAT_PEND]      = pend_flag;
    end
  end

  assign ce_idx = ext_addr[CE_SEL_LSB +: SEL_W];

  nsr_ce_mux #(.NUM_CE(NUM_CE), .SEL_W(SEL_W)) u_ce (
    .direct_i(ce_direct_q), .sel_i(ce_sel_q), .access_i(ext_access),
    .idx_i(ce_idx), .ce_n_o(ce_n)
  );

  assign irq             = irq_en_q & pend_flag;
  assign cfg_wait_states = cfg_q.wait_states;
  assign cfg_wait_low    = cfg_q.wait_low;
  assign cfg_addr_cycles = cfg_q.addr_cycles;
endmodule

// File: rtl/nsr_status_regs_chk.sv
module nsr_status_regs_chk #(
  parameter int REG_ADDR_W = 4,
  parameter int NUM_CE     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [7:0]            reg_wdata,
  input logic                  rb_rise,
  input logic                  pend_flag,
  input logic                  dma_flag,
  input logic                  dma_done_pulse,
  input logic                  cmd_issue,
  input logic                  ce_direct,
  input logic [NUM_CE-1:0]     ce_n,
  input logic                  irq
);
  logic pend_wclr, en_off_wr;
  assign pend_wclr = reg_wr && (reg_addr == REG_ADDR_W'(1)) && reg_wdata[7];
  assign en_off_wr = reg_wr && (reg_addr == '0) && !reg_wdata[6];

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> pend_flag);
  assert_pend_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_flag && !rb_rise) |=> !pend_flag);
  assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flag && !pend_wclr) |=> pend_flag);
  assert_irq_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_off_wr |=> !irq);
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wclr && !rb_rise) |=> !irq);
  assert_dma_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_pulse |=> dma_flag);
  assert_dma_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && !dma_done_pulse) |=> !dma_flag);
  assert_ce_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_direct |-> ($countones(~ce_n) <= 1));
endmodule

bind nsr_status_regs nsr_status_regs_chk #(.REG_ADDR_W(REG_ADDR_W), .NUM_CE(NUM_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rb_rise(rb_rise), .pend_flag(pend_flag), .dma_flag(dma_flag),
  .dma_done_pulse(dma_done_pulse), .cmd_issue(cmd_issue), .ce_direct(ce_direct_q),
  .ce_n(ce_n), .irq(irq)
);

// File: tb/nsr_status_regs_tb.sv
`timescale 1ns/1ps
module nsr_status_regs_tb;
  localparam int AW = 4;
  localparam int NCE = 4;
  localparam int EAW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rb_pin = 1'b1, ctrl_busy = 1'b0, dma_done_pulse = 1'b0, cmd_issue = 1'b0;
  logic ext_access = 1'b0;
  logic [EAW-1:0] ext_addr = '0;
  logic [NCE-1:0] ce_n;
  logic irq, cfg_wait_low;
  logic [1:0] cfg_wait_states, cfg_addr_cycles;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nsr_status_regs #(.REG_ADDR_W(AW), .NUM_CE(NCE), .SYNC_STAGES(2),
                    .EXT_ADDR_W(EAW), .CE_SEL_LSB(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rb_pin(rb_pin),
    .ctrl_busy(ctrl_busy), .dma_done_pulse(dma_done_pulse), .cmd_issue(cmd_issue),
    .ext_access(ext_access), .ext_addr(ext_addr), .ce_n(ce_n), .irq(irq),
    .cfg_wait_states(cfg_wait_states), .cfg_wait_low(cfg_wait_low),
    .cfg_addr_cycles(cfg_addr_cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl after reset", d, 8'h00);
    rd(1, d); chk("R1 stat after reset", d, 8'h40);
    chk("R1 ce_n after reset", ce_n, 4'hF);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_rb_edge;
    logic [7:0] d;
    @(negedge clk); rb_pin = 1'b0;
    repeat (4) @(posedge clk);
    rd(1, d); chk("R5 live low", d[6], 0);
    chk("R2 fall sets nothing", d[7], 0);
    @(negedge clk); rb_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(1, d); chk("R5 live after two edges", d[6], 1);
    chk("R2 not yet pending", d[7], 0);
    rd(1, d); chk("R2 pending on third edge", d[7], 1);
    wr(1, 8'h00);
    rd(1, d); chk("R3 write zero keeps pending", d[7], 1);
    wr(1, 8'h80);
    repeat (4) @(posedge clk);
    rd(1, d); chk("R2 held high sets once / R3 cleared", d[7], 0);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(0, 8'h40);
    chk("R4 enabled no pending", irq, 0);
    @(negedge clk); rb_pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rb_pin = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R4 irq raised", irq, 1);
    wr(0, 8'h00);
    chk("R4 disable drops irq", irq, 0);
    rd(1, d); chk("R4 pending stays while disabled", d[7], 1);
    wr(0, 8'h40);
    chk("R4 re-enable raises irq", irq, 1);
    wr(1, 8'h80);
    chk("R4 clear drops irq", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_pend_race;
    logic [7:0] d;
    @(negedge clk); rb_pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rb_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0;
    rd(1, d); chk("R7 pending set wins over clear", d[7], 1);
    wr(1, 8'h80);
    rd(1, d); chk("R3 pending cleared after race", d[7], 0);
  endtask

  task automatic t_dma;
    logic [7:0] d;
    @(negedge clk); dma_done_pulse = 1'b1;
    @(negedge clk); dma_done_pulse = 1'b0;
    rd(1, d); chk("R6 dma done set", d[5], 1);
    wr(1, 8'h00);
    rd(1, d); chk("R6 write zero keeps dma done", d[5], 1);
    wr(1, 8'h20);
    rd(1, d); chk("R6 write one clears dma done", d[5], 0);
    @(negedge clk); dma_done_pulse = 1'b1;
    @(negedge clk); dma_done_pulse = 1'b0;
    @(negedge clk); cmd_issue = 1'b1;
    @(negedge clk); cmd_issue = 1'b0;
    rd(1, d); chk("R6 command clears dma done", d[5], 0);
    @(negedge clk); dma_done_pulse = 1'b1; cmd_issue = 1'b1;
    @(negedge clk); dma_done_pulse = 1'b0; cmd_issue = 1'b0;
    rd(1, d); chk("R7 dma set wins over command", d[5], 1);
    @(negedge clk); dma_done_pulse = 1'b1;
    reg_wr = 1'b1; reg_addr = 1; reg_wdata = 8'h20;
    @(negedge clk); dma_done_pulse = 1'b0; reg_wr = 1'b0;
    rd(1, d); chk("R7 dma set wins over write clear", d[5], 1);
    wr(1, 8'h20);
  endtask

  task automatic t_ce;
    logic [7:0] d;
    wr(0, 8'h16);
    #0.5; chk("R8 direct ce_n", ce_n, 4'b1010);
    rd(0, d); chk("R8 readback", d, 8'h16);
    wr(0, 8'h3E);
    chk("R8 direct all low", ce_n, 4'b0000);
    wr(0, 8'h3C);
    chk("R9 decoded idle", ce_n, 4'hF);
    @(negedge clk); ext_addr = 8'h80; ext_access = 1'b1; #0.5;
    chk("R9 decoded index 2", ce_n, 4'b1011);
    ext_addr = 8'hC0; #0.5;
    chk("R9 decoded index 3", ce_n, 4'b0111);
    ext_addr = 8'h3F; #0.5;
    chk("R9 decoded index 0", ce_n, 4'b1110);
    ext_access = 1'b0; #0.5;
    chk("R9 access ended", ce_n, 4'hF);
    wr(0, 8'h00);
  endtask

  task automatic t_busy_map;
    logic [7:0] d;
    ctrl_busy = 1'b1;
    rd(0, d); chk("R10 busy reads 1", d[0], 1);
    ctrl_busy = 1'b0;
    wr(0, 8'h81);
    rd(0, d); chk("R10 bits 7 and 0 not stored", d, 8'h00);
    wr(2, 8'hFF);
    rd(0, d); chk("R10 unmapped write ctrl unchanged", d, 8'h00);
    chk("R10 unmapped write ce_n unchanged", ce_n, 4'hF);
    rd(2, d); chk("R10 unmapped reads 0", d, 8'h00);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    wr(1, 8'h1F);
    rd(1, d); chk("R11 cfg readback", d[4:0], 5'h1F);
    chk("R11 wait states", cfg_wait_states, 2'd3);
    chk("R11 wait low", cfg_wait_low, 1);
    chk("R11 addr cycles", cfg_addr_cycles, 2'd3);
    wr(1, 8'h0A);
    chk("R11 wait states b", cfg_wait_states, 2'd1);
    chk("R11 wait low b", cfg_wait_low, 0);
    chk("R11 addr cycles b", cfg_addr_cycles, 2'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_rb_edge();
    t_irq();
    t_pend_race();
    t_dma();
    t_ce();
    t_busy_map();
    t_cfg();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule